// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer with Cascade Select

This block carries an interrupt controller through the processor's two-strobe acknowledge handshake. It sits between the priority resolver, which names the winning request level, and the processor data bus. On the first strobe it tells the resolver to commit the winner to the in-service set. On the second strobe it places an 8-bit vector on the bus. The vector is formed from the programmed base with its low three bits replaced by the level.

The same block serves both a master and a slave controller. A master whose winning input has a slave wired to it does not drive the vector. Instead it broadcasts the input number on a 3-bit cascade bus, from the first strobe until the second one ends. A slave compares that bus with its own wired identity when its second strobe begins. Only the matching slave commits its own winner and drives the vector. When automatic end-of-service is selected, the block issues a one-cycle clear request for the committed level after the second strobe ends.

The acknowledge strobe is a synchronous level input. Each pulse is a high interval on that input. A pulse starts on the first cycle the input is sampled high and ends on the first cycle it is sampled low.

Top module: `intack_ctrl`

## Requirements
- R1: In a master (`is_master_i`=1) with `win_valid_i`=1 at the start of the first pulse, `grant_o` is high for exactly one cycle, in the cycle after the pulse start is sampled, with `grant_lvl_o` equal to the winning level; `vec_oe_o` stays low for the whole first pulse.
- R2: When this controller owns the vector, `vec_oe_o` is high from the cycle after the second pulse starts until the cycle in which its end is sampled, and `vec_o` equals `{vec_base_i[7:3], level}` (level in bits 2:0); `vec_oe_o` falls one cycle after the second pulse ends.
- R3: The level in the vector is the one latched when it was granted; later changes of `win_lvl_i` are ignored.
- R4: If `win_valid_i`=0 when the grant would occur, no grant is issued, the vector carries level 7 (bits 2:0 = 111), and no clear request follows even with auto-end on.
- R5: With `aeoi_i`=1 and a granted level, `clr_o` is high for exactly one cycle, the cycle after the second pulse end is sampled, with `clr_lvl_o` equal to that level; with `aeoi_i`=0, `clr_o` stays low.
- R6: In a master whose winning level L has `casc_map_i[L]`=1, `casc_oe_o`=1 and `casc_o`=L from the cycle after the first pulse starts until the cycle after the second pulse ends; the master keeps `vec_oe_o` low throughout.
- R7: In a master whose winning level has `casc_map_i` bit 0, `casc_oe_o` stays low for the whole handshake.
- R8: In a slave (`is_master_i`=0), `casc_map_i[2:0]` is its identity. At the second pulse start, if `casc_i` equals that identity, the slave grants its winner (`grant_o` one cycle, in the cycle after) and drives the vector. Otherwise it grants nothing, drives nothing and issues no clear request. A slave grants nothing on the first pulse.
- R9: A slave never enables the cascade outputs.
- R10: While reset is asserted, and until the first pulse, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inta_i | input | 1 | Acknowledge strobe, synchronous, active high |
| win_valid_i | input | 1 | Resolver has a pending winner |
| win_lvl_i | input | 3 | Resolver's winning level |
| vec_base_i | input | 8 | Vector base; upper five bits used |
| aeoi_i | input | 1 | Automatic end-of-service enable |
| is_master_i | input | 1 | 1 = master, 0 = slave |
| casc_map_i | input | 8 | Master: slave-present bit per input; slave: identity in bits 2:0 |
| casc_i | input | 3 | Cascade bus as seen by a slave |
| grant_o | output | 1 | One-cycle commit strobe to the resolver |
| grant_lvl_o | output | 3 | Level being committed |
| vec_o | output | 8 | Vector byte |
| vec_oe_o | output | 1 | Drive enable for the vector |
| casc_o | output | 3 | Cascade bus value driven by a master |
| casc_oe_o | output | 1 | Cascade bus drive enable |
| clr_o | output | 1 | One-cycle automatic clear request |
| clr_lvl_o | output | 3 | Level to clear |

## Verification
A bad latched level shows on the vector byte one cycle after the second pulse starts, and on the clear level one cycle after that pulse ends. A bad ownership or cascade flag shows within a cycle of a pulse edge. It appears either as two drivers (cascade and vector enabled together) or as a silent bus in a second pulse. A stuck handshake state either withholds the grant one cycle after the first pulse starts, or opens the vector enable during the first pulse.

// File: rtl/intack_pkg.sv
package intack_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_P1   = 2'd1,
    ACK_GAP  = 2'd2,
    ACK_P2   = 2'd3
  } ack_state_e;

endpackage

// File: rtl/intack_edge.sv
module intack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);

  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
  assign fall_o = ~strobe_i & strobe_q;

endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       fall_i,
  output ack_state_e state_o,
  output logic       enter_p1_o,
  output logic       enter_p2_o,
  output logic       leave_p2_o
);

  ack_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ACK_IDLE: if (rise_i) state_n = ACK_P1;
      ACK_P1:   if (fall_i) state_n = ACK_GAP;
      ACK_GAP:  if (rise_i) state_n = ACK_P2;
      ACK_P2:   if (fall_i) state_n = ACK_IDLE;
      default:  state_n = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ACK_IDLE;
    else         state_q <= state_n;
  end

  assign state_o    = state_q;
  assign enter_p1_o = (state_q == ACK_IDLE) & rise_i;
  assign enter_p2_o = (state_q == ACK_GAP)  & rise_i;
  assign leave_p2_o = (state_q == ACK_P2)   & fall_i;

endmodule

// File: rtl/intack_path.sv
module intack_path #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned VEC_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enter_p1_i,
  input  logic                   enter_p2_i,
  input  logic                   leave_p2_i,
  input  logic                   win_valid_i,
  input  logic [LVL_W-1:0]       win_lvl_i,
  input  logic [VEC_W-1:0]       vec_base_i,
  input  logic                   aeoi_i,
  input  logic                   is_master_i,
  input  logic [(1<<LVL_W)-1:0]  casc_map_i,
  input  logic [LVL_W-1:0]       casc_i,
  output logic                   grant_o,
  output logic [LVL_W-1:0]       grant_lvl_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   vec_oe_o,
  output logic [LVL_W-1:0]       casc_o,
  output logic                   casc_oe_o,
  output logic                   clr_o,
  output logic [LVL_W-1:0]       clr_lvl_o
);

  localparam int unsigned BASE_W = VEC_W - LVL_W;
  localparam logic [LVL_W-1:0] SPUR_LVL = {LVL_W{1'b1}};

  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             casc_q, casc_n;
  logic             drive_q, drive_n;
  logic             own_q, own_n;
  logic             grant_q, grant_n;
  logic             clr_q, clr_n;
  logic             upd_en;
  logic             slave_hit;

  assign slave_hit = (casc_i == casc_map_i[LVL_W-1:0]);
  assign upd_en    = enter_p1_i | enter_p2_i | leave_p2_i;

  always_comb begin
    lvl_n   = lvl_q;
    casc_n  = casc_q;
    drive_n = drive_q;
    own_n   = own_q;
    grant_n = 1'b0;
    clr_n   = 1'b0;
    if (enter_p1_i) begin
      drive_n = 1'b0;
      if (is_master_i) begin
        grant_n = win_valid_i;
        own_n   = win_valid_i;
        lvl_n   = win_valid_i ? win_lvl_i : SPUR_LVL;
        casc_n  = win_valid_i & casc_map_i[win_lvl_i];
      end else begin
        own_n  = 1'b0;
        casc_n = 1'b0;
      end
    end
    if (enter_p2_i) begin
      if (is_master_i) begin
        drive_n = ~casc_q;
      end else begin
        drive_n = slave_hit;
        grant_n = slave_hit & win_valid_i;
        own_n   = slave_hit & win_valid_i;
        lvl_n   = (slave_hit & win_valid_i) ? win_lvl_i : SPUR_LVL;
      end
    end
    if (leave_p2_i) begin
      clr_n   = aeoi_i & own_q;
      drive_n = 1'b0;
      casc_n  = 1'b0;
      own_n   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      casc_q  <= 1'b0;
      drive_q <= 1'b0;
      own_q   <= 1'b0;
    end else if (upd_en) begin
      lvl_q   <= lvl_n;
      casc_q  <= casc_n;
      drive_q <= drive_n;
      own_q   <= own_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      grant_q <= grant_n;
      clr_q   <= clr_n;
    end
  end

  assign grant_o     = grant_q;
  assign grant_lvl_o = lvl_q;
  assign vec_oe_o    = drive_q;
  assign vec_o       = drive_q ? {vec_base_i[VEC_W-1 -: BASE_W], lvl_q} : '0;
  assign casc_oe_o   = casc_q;
  assign casc_o      = casc_q ? lvl_q : '0;
  assign clr_o       = clr_q;
  assign clr_lvl_o   = lvl_q;

endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
#(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned VEC_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inta_i,
  input  logic                  win_valid_i,
  input  logic [LVL_W-1:0]      win_lvl_i,
  input  logic [VEC_W-1:0]      vec_base_i,
  input  logic                  aeoi_i,
  input  logic                  is_master_i,
  input  logic [(1<<LVL_W)-1:0] casc_map_i,
  input  logic [LVL_W-1:0]      casc_i,
  output logic                  grant_o,
  output logic [LVL_W-1:0]      grant_lvl_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  vec_oe_o,
  output logic [LVL_W-1:0]      casc_o,
  output logic                  casc_oe_o,
  output logic                  clr_o,
  output logic [LVL_W-1:0]      clr_lvl_o
);

  logic       rst_meta_q, rst_sync_n;
  logic       rise, fall;
  logic       enter_p1, enter_p2, leave_p2;
  ack_state_e seq_state;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  intack_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .strobe_i (inta_i),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  intack_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .rise_i     (rise),
    .fall_i     (fall),
    .state_o    (seq_state),
    .enter_p1_o (enter_p1),
    .enter_p2_o (enter_p2),
    .leave_p2_o (leave_p2)
  );

  intack_path #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .enter_p1_i  (enter_p1),
    .enter_p2_i  (enter_p2),
    .leave_p2_i  (leave_p2),
    .win_valid_i (win_valid_i),
    .win_lvl_i   (win_lvl_i),
    .vec_base_i  (vec_base_i),
    .aeoi_i      (aeoi_i),
    .is_master_i (is_master_i),
    .casc_map_i  (casc_map_i),
    .casc_i      (casc_i),
    .grant_o     (grant_o),
    .grant_lvl_o (grant_lvl_o),
    .vec_o       (vec_o),
    .vec_oe_o    (vec_oe_o),
    .casc_o      (casc_o),
    .casc_oe_o   (casc_oe_o),
    .clr_o       (clr_o),
    .clr_lvl_o   (clr_lvl_o)
  );

endmodule

// File: rtl/intack_ctrl_chk.sv
module intack_ctrl_chk
  import intack_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       inta_i,
  input logic       is_master_i,
  input ack_state_e state_i,
  input logic       grant_o,
  input logic       vec_oe_o,
  input logic       casc_oe_o,
  input logic       clr_o
);

  assert_quiet_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ACK_P1) |-> !vec_oe_o);

  assert_grant_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);

  assert_drive_in_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (inta_i || $past(inta_i)));

  assert_clr_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);

  assert_casc_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_oe_o |-> !vec_oe_o);

  assert_slave_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_master_i && $stable(is_master_i) && !$past(casc_oe_o)) |-> !casc_oe_o);

endmodule

bind intack_ctrl intack_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .inta_i      (inta_i),
  .is_master_i (is_master_i),
  .state_i     (seq_state),
  .grant_o     (grant_o),
  .vec_oe_o    (vec_oe_o),
  .casc_oe_o   (casc_oe_o),
  .clr_o       (clr_o)
);

// File: tb/intack_ctrl_bench.sv
module intack_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inta, win_valid, aeoi, is_master;
  logic [2:0] win_lvl, casc_in;
  logic [7:0] vec_base, casc_map;
  logic       grant, vec_oe, casc_oe, clr;
  logic [2:0] grant_lvl, casc_out, clr_lvl;
  logic [7:0] vec;

  int n_chk = 0;
  int n_bad = 0;

  // observations of one handshake
  logic       p1_grant, p1_oe, p1_coe, p1_late_oe, p1_late_grant;
  logic [2:0] p1_lvl, p1_casc;
  logic       p2_grant, p2_oe, p2_coe, p2_late_oe;
  logic [2:0] p2_lvl, p2_casc;
  logic [7:0] p2_vec;
  logic       e_clr, e_oe, e_coe, e_clr2;
  logic [2:0] e_lvl;

  always #4 clk = ~clk;

  intack_ctrl u_intack_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .inta_i(inta), .win_valid_i(win_valid),
    .win_lvl_i(win_lvl), .vec_base_i(vec_base), .aeoi_i(aeoi),
    .is_master_i(is_master), .casc_map_i(casc_map), .casc_i(casc_in),
    .grant_o(grant), .grant_lvl_o(grant_lvl), .vec_o(vec), .vec_oe_o(vec_oe),
    .casc_o(casc_out), .casc_oe_o(casc_oe), .clr_o(clr), .clr_lvl_o(clr_lvl)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    inta = 0; win_valid = 1; win_lvl = 0; aeoi = 0; is_master = 1;
    vec_base = 8'h40; casc_map = 8'h00; casc_in = 3'd0;
  endtask

  // one full two-pulse handshake; optional change of winner after grant
  task automatic ack_seq(input bit chg, input logic [2:0] new_lvl);
    @(negedge clk) inta = 1;
    @(negedge clk);
    p1_grant = grant; p1_lvl = grant_lvl; p1_oe = vec_oe;
    p1_coe = casc_oe; p1_casc = casc_out;
    if (chg) win_lvl = new_lvl;
    @(negedge clk);
    p1_late_grant = grant;
    @(negedge clk);
    p1_late_oe = vec_oe;
    inta = 0;
    repeat (2) @(negedge clk);
    inta = 1;
    @(negedge clk);
    p2_grant = grant; p2_lvl = grant_lvl; p2_oe = vec_oe; p2_vec = vec;
    p2_coe = casc_oe; p2_casc = casc_out;
    @(negedge clk);
    p2_late_oe = vec_oe;
    inta = 0;
    @(negedge clk);
    e_clr = clr; e_lvl = clr_lvl; e_oe = vec_oe; e_coe = casc_oe;
    @(negedge clk);
    e_clr2 = clr;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10", "grant in reset", grant, 0);
    chk("R10", "vec_oe in reset", vec_oe, 0);
    chk("R10", "casc_oe in reset", casc_oe, 0);
    chk("R10", "clr in reset", clr, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10", "outputs idle after release", {grant, vec_oe, casc_oe, clr}, 0);
  endtask

  task automatic t_master_plain();
    defaults(); win_lvl = 3'd5; vec_base = 8'h40;
    ack_seq(0, 0);
    chk("R1", "grant first pulse", p1_grant, 1);
    chk("R1", "grant level", p1_lvl, 5);
    chk("R1", "grant one cycle", p1_late_grant, 0);
    chk("R1", "no drive in first pulse", {p1_oe, p1_late_oe}, 0);
    chk("R2", "drive second pulse", {p2_oe, p2_late_oe}, 2'b11);
    chk("R2", "vector", p2_vec, 8'h45);
    chk("R2", "release after pulse", e_oe, 0);
    chk("R5", "no clear without auto-end", {e_clr, e_clr2}, 0);
    chk("R7", "no cascade", {p1_coe, p2_coe}, 0);
  endtask

  task automatic t_aeoi();
    defaults(); win_lvl = 3'd2; vec_base = 8'h0F; aeoi = 1;
    ack_seq(0, 0);
    chk("R2", "vector base low bits replaced", p2_vec, 8'h0A);
    chk("R5", "clear pulse", e_clr, 1);
    chk("R5", "clear level", e_lvl, 2);
    chk("R5", "clear one cycle", e_clr2, 0);
  endtask

  task automatic t_latch();
    defaults(); win_lvl = 3'd3; vec_base = 8'h70;
    ack_seq(1, 3'd6);
    chk("R3", "vector keeps granted level", p2_vec, 8'h73);
    chk("R3", "no second grant", p2_grant, 0);
  endtask

  task automatic t_spurious();
    defaults(); win_valid = 0; win_lvl = 3'd1; aeoi = 1; vec_base = 8'h20;
    ack_seq(0, 0);
    chk("R4", "no grant", p1_grant, 0);
    chk("R4", "spurious vector", p2_vec, 8'h27);
    chk("R4", "spurious drive", p2_oe, 1);
    chk("R4", "no clear", {e_clr, e_clr2}, 0);
  endtask

  task automatic t_casc_master();
    defaults(); casc_map = 8'h03; win_lvl = 3'd1; aeoi = 1;
    ack_seq(0, 0);
    chk("R6", "cascade enable first pulse", p1_coe, 1);
    chk("R6", "cascade value first pulse", p1_casc, 1);
    chk("R6", "cascade held second pulse", {p2_coe, p2_casc}, 4'b1001);
    chk("R6", "master silent on vector", {p2_oe, p2_late_oe}, 0);
    chk("R6", "cascade off after", e_coe, 0);
    chk("R5", "master clears its own level", {e_clr, e_lvl}, 4'b1001);
  endtask

  task automatic t_master_nocasc();
    defaults(); casc_map = 8'h03; win_lvl = 3'd4;
    ack_seq(0, 0);
    chk("R7", "no cascade for plain input", {p1_coe, p2_coe}, 0);
    chk("R7", "vector driven", {p2_oe, p2_vec}, 9'h144);
  endtask

  task automatic t_slave_hit();
    defaults(); is_master = 0; casc_map = 8'h02; casc_in = 3'd2;
    win_lvl = 3'd6; vec_base = 8'h70; aeoi = 1;
    ack_seq(0, 0);
    chk("R8", "slave no grant first pulse", p1_grant, 0);
    chk("R8", "slave grant on match", {p2_grant, p2_lvl}, 4'b1110);
    chk("R8", "slave vector", {p2_oe, p2_vec}, 9'h176);
    chk("R8", "slave clear", {e_clr, e_lvl}, 4'b1110);
    chk("R9", "slave cascade off", {p1_coe, p2_coe, e_coe}, 0);
  endtask

  task automatic t_slave_miss();
    defaults(); is_master = 0; casc_map = 8'h02; casc_in = 3'd5;
    win_lvl = 3'd6; aeoi = 1;
    ack_seq(0, 0);
    chk("R8", "unmatched slave no grant", {p1_grant, p2_grant}, 0);
    chk("R8", "unmatched slave silent", {p2_oe, p2_late_oe}, 0);
    chk("R8", "unmatched slave no clear", {e_clr, e_clr2}, 0);
    chk("R9", "unmatched slave cascade off", {p1_coe, p2_coe}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_master_plain();
    t_aeoi();
    t_latch();
    t_spurious();
    t_casc_master();
    t_master_nocasc();
    t_slave_hit();
    t_slave_miss();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule